// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits next to a load/store path and carries out the two halves of an atomic read-modify-write sequence. A link request reads a word from memory and returns it for the destination register. It also records a reservation made of the requesting context, the word address and the value that was read. A later conditional request from the same context to the same address consumes that reservation. The block then reads the word again and writes the new data only if memory still holds the value seen at link time. The destination register receives 1 when the store went ahead and 0 when it did not.

Each request supplies an operation bit, a context number, a base register value, a 16-bit signed offset and the store data. Memory is reached through a single request/acknowledge port that can answer with a fault. Every request ends with a one-cycle `done` pulse. With that pulse comes either a register write or an exception code with the faulting address. Address checks are made before any memory access.

Top module: `llsc_monitor`

## Requirements
- R1: The effective address is the base value plus the 16-bit offset taken as a two's-complement number, modulo 2^32. Every memory access and every reported exception address uses this value.
- R2: An address whose top bit is 1, or whose two low bits are not both 0, ends the request with exc_code 1 (address error). It makes no memory access, does not write the register and leaves the reservation as it was.
- R3: A link request (req_op 0) reads the word, returns it on rd_data with rd_we, and records the context, address and word as a valid reservation.
- R4: A conditional request (req_op 1) with no valid reservation, with a different context or with a different address writes rd_data 0. It makes no memory access and leaves any reservation unchanged.
- R5: A conditional request whose context and address match the reservation consumes the reservation whatever the outcome. A second conditional request to the same word therefore makes no access.
- R6: After a match the word is read again. If it equals the recorded value, req_wdata is written to that address and rd_data is 1. Otherwise no write is issued and rd_data is 0.
- R7: A read fault in either request ends it with exc_code 2 (load miss). A write fault ends it with exc_code 3 (store miss). In both cases exc_addr holds the effective address and the register is not written.
- R8: mem_req stays high, with mem_addr, mem_we and mem_wdata stable, until mem_ack. `done` pulses for one cycle at the end of each request. A request is accepted only while req_ready is high.
- R9: Reset clears the reservation, so a conditional request made straight after reset writes 0 without touching memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Monitor idle, request taken this cycle |
| req_op | input | 1 | 0 = link, 1 = conditional store |
| req_ctx | input | CTX_W | Requesting context number |
| req_base | input | AW | Base register value |
| req_ofs | input | OFS_W | Signed address offset |
| req_wdata | input | DW | Data for the conditional store |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Access finished this cycle |
| mem_fault | input | 1 | Access failed (valid with mem_ack) |
| mem_rdata | input | DW | Read data (valid with mem_ack) |
| done | output | 1 | Request finished (one cycle) |
| rd_we | output | 1 | Destination register write |
| rd_data | output | DW | Value for the destination register |
| exc_valid | output | 1 | Request ended in an exception |
| exc_code | output | 2 | 1 address error, 2 load miss, 3 store miss |
| exc_addr | output | AW | Faulting effective address |

## Verification
The `done` cycle of one request and the acceptance of the next fall in the same cycle. At that point a link's reservation is written in the same edge that frees the monitor for a conditional request that depends on it. The bench issues requests back to back with no idle cycle between them. A behavioural model of the reservation decides on its own whether each conditional request should find a live reservation, and the bench compares the register result, the number of memory accesses and the memory contents against that model. The bench also changes memory behind the monitor's back between a link and its conditional store to confirm that the value comparison, not just the address match, decides the result.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic {
    OP_LINK = 1'b0,
    OP_COND = 1'b1
  } llsc_op_e;

  typedef enum logic [1:0] {
    EXC_NONE   = 2'd0,
    EXC_ADDR   = 2'd1,
    EXC_LDMISS = 2'd2,
    EXC_STMISS = 2'd3
  } llsc_exc_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_LINK_RD = 2'd1,
    ST_COND_RD = 2'd2,
    ST_COND_WR = 2'd3
  } llsc_state_e;

endpackage

// File: rtl/llsc_agen.sv
module llsc_agen #(
  parameter int AW         = 32,
  parameter int OFS_W      = 16,
  parameter int ALIGN_BITS = 2
) (
  input  logic [AW-1:0]    base,
  input  logic [OFS_W-1:0] ofs,
  output logic [AW-1:0]    ea,
  output logic             bad
);

  // base + sign-extended offset, wrapping modulo 2^AW
  function automatic logic [AW-1:0] offset_add(input logic [AW-1:0] b, input logic [OFS_W-1:0] o);
    logic [AW-1:0] sx;
    sx = {{(AW-OFS_W){o[OFS_W-1]}}, o};
    return b + sx;
  endfunction

  // upper half of the space or not word aligned
  function automatic logic misplaced(input logic [AW-1:0] a);
    return a[AW-1] | (|a[ALIGN_BITS-1:0]);
  endfunction

  assign ea  = offset_add(base, ofs);
  assign bad = misplaced(ea);

endmodule

// File: rtl/llsc_resv.sv
module llsc_resv #(
  parameter int CTX_W = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set,
  input  logic             clr,
  input  logic [CTX_W-1:0] set_ctx,
  input  logic [AW-1:0]    set_addr,
  input  logic [DW-1:0]    set_val,
  input  logic [CTX_W-1:0] chk_ctx,
  input  logic [AW-1:0]    chk_addr,
  output logic             hit,
  output logic             valid,
  output logic [AW-1:0]    saved_addr,
  output logic [DW-1:0]    saved_val
);

  logic [CTX_W-1:0] saved_ctx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid      <= 1'b0;
      saved_ctx  <= '0;
      saved_addr <= '0;
      saved_val  <= '0;
    end else if (set) begin
      valid      <= 1'b1;
      saved_ctx  <= set_ctx;
      saved_addr <= set_addr;
      saved_val  <= set_val;
    end else if (clr) begin
      valid      <= 1'b0;
    end
  end

  assign hit = valid && (saved_ctx == chk_ctx) && (saved_addr == chk_addr);

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int CTX_W = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_op,
  input  logic [CTX_W-1:0] req_ctx,
  input  logic [AW-1:0]    req_base,
  input  logic [OFS_W-1:0] req_ofs,
  input  logic [DW-1:0]    req_wdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ack,
  input  logic             mem_fault,
  input  logic [DW-1:0]    mem_rdata,
  output logic             done,
  output logic             rd_we,
  output logic [DW-1:0]    rd_data,
  output logic             exc_valid,
  output logic [1:0]       exc_code,
  output logic [AW-1:0]    exc_addr
);

  localparam int ALIGN_BITS = $clog2(DW / 8);

  llsc_state_e      state;
  logic [CTX_W-1:0] cur_ctx;
  logic [AW-1:0]    cur_addr;
  logic [DW-1:0]    cur_wdata;
  llsc_exc_e        exc_q;

  logic [AW-1:0] ea;
  logic          ea_bad;
  logic          resv_hit, resv_valid, resv_set, resv_clr;
  logic [AW-1:0] resv_addr;
  logic [DW-1:0] resv_val;

  // named events for assertions
  logic acc, acc_link, acc_cond, cond_nores, cmp_equal;

  llsc_agen #(.AW(AW), .OFS_W(OFS_W), .ALIGN_BITS(ALIGN_BITS)) i_agen (
    .base(req_base), .ofs(req_ofs), .ea(ea), .bad(ea_bad)
  );

  llsc_resv #(.CTX_W(CTX_W), .AW(AW), .DW(DW)) i_resv (
    .clk(clk), .rst_n(rst_n), .set(resv_set), .clr(resv_clr),
    .set_ctx(cur_ctx), .set_addr(cur_addr), .set_val(mem_rdata),
    .chk_ctx(req_ctx), .chk_addr(ea),
    .hit(resv_hit), .valid(resv_valid), .saved_addr(resv_addr), .saved_val(resv_val)
  );

  assign acc        = req_valid && (state == ST_IDLE);
  assign acc_link   = acc && !ea_bad && (req_op == OP_LINK);
  assign acc_cond   = acc && !ea_bad && (req_op == OP_COND);
  assign cond_nores = acc_cond && !resv_hit;
  assign cmp_equal  = (mem_rdata == resv_val);

  assign resv_set = (state == ST_LINK_RD) && mem_ack && !mem_fault;
  assign resv_clr = acc_cond && resv_hit;

  assign req_ready = (state == ST_IDLE);
  assign mem_req   = (state != ST_IDLE);
  assign mem_we    = (state == ST_COND_WR);
  assign mem_addr  = cur_addr;
  assign mem_wdata = cur_wdata;
  assign exc_code  = exc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_ctx   <= '0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      done      <= 1'b0;
      rd_we     <= 1'b0;
      rd_data   <= '0;
      exc_valid <= 1'b0;
      exc_q     <= EXC_NONE;
      exc_addr  <= '0;
    end else begin
      done      <= 1'b0;
      rd_we     <= 1'b0;
      exc_valid <= 1'b0;
      exc_q     <= EXC_NONE;
      unique case (state)
        ST_IDLE: if (acc) begin
          cur_ctx   <= req_ctx;
          cur_addr  <= ea;
          cur_wdata <= req_wdata;
          if (ea_bad) begin
            done <= 1'b1; exc_valid <= 1'b1; exc_q <= EXC_ADDR; exc_addr <= ea;
          end else if (acc_link) begin
            state <= ST_LINK_RD;
          end else if (resv_hit) begin
            state <= ST_COND_RD;
          end else begin
            done <= 1'b1; rd_we <= 1'b1; rd_data <= '0;
          end
        end
        ST_LINK_RD: if (mem_ack) begin
          state <= ST_IDLE;
          done  <= 1'b1;
          if (mem_fault) begin
            exc_valid <= 1'b1; exc_q <= EXC_LDMISS; exc_addr <= cur_addr;
          end else begin
            rd_we <= 1'b1; rd_data <= mem_rdata;
          end
        end
        ST_COND_RD: if (mem_ack) begin
          if (mem_fault) begin
            state <= ST_IDLE; done <= 1'b1;
            exc_valid <= 1'b1; exc_q <= EXC_LDMISS; exc_addr <= cur_addr;
          end else if (cmp_equal) begin
            state <= ST_COND_WR;
          end else begin
            state <= ST_IDLE; done <= 1'b1; rd_we <= 1'b1; rd_data <= '0;
          end
        end
        ST_COND_WR: if (mem_ack) begin
          state <= ST_IDLE;
          done  <= 1'b1;
          if (mem_fault) begin
            exc_valid <= 1'b1; exc_q <= EXC_STMISS; exc_addr <= cur_addr;
          end else begin
            rd_we <= 1'b1; rd_data <= DW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: an access holds its request and payload until acknowledged
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R4: a conditional request without a live matching reservation fails at once
  assert_nores_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cond_nores |=> done && rd_we && (rd_data == '0) && !mem_req);

  // R5: a matching conditional request consumes the reservation
  assert_consume_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resv_clr |=> !resv_valid);

  // R6: the conditional write goes only to the reserved address, after consumption
  assert_wr_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !resv_valid && (mem_addr == resv_addr));

  // R3: a successful link leaves a valid reservation
  assert_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resv_set |=> resv_valid);

  // R7: an exception never comes with a register write
  assert_exc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> done && !rd_we);

  // R2: an address error reports a misplaced address
  assert_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && (exc_code == EXC_ADDR) |-> exc_addr[AW-1] || (|exc_addr[ALIGN_BITS-1:0]));

endmodule

// File: tb/test_llsc_monitor.sv
module test_llsc_monitor;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_op = 1'b0;
  logic [3:0]  req_ctx = '0;
  logic [31:0] req_base = '0;
  logic [15:0] req_ofs = '0;
  logic [31:0] req_wdata = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic        mem_fault = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done, rd_we, exc_valid;
  logic [31:0] rd_data, exc_addr;
  logic [1:0]  exc_code;

  always #5 clk = ~clk;

  llsc_monitor i_llsc_monitor (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_ctx(req_ctx),
    .req_base(req_base), .req_ofs(req_ofs), .req_wdata(req_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_fault(mem_fault), .mem_rdata(mem_rdata),
    .done(done), .rd_we(rd_we), .rd_data(rd_data),
    .exc_valid(exc_valid), .exc_code(exc_code), .exc_addr(exc_addr)
  );

  int checks = 0;
  int errors = 0;

  // memory seen by the monitor and the model's own copy
  logic [31:0] bmem   [logic [31:0]];
  logic [31:0] shadow [logic [31:0]];
  logic [31:0] flt_rd = 32'hFFFF_FFFF;
  logic [31:0] flt_wr = 32'hFFFF_FFFF;
  int lat  = 0;
  int wcnt = 0;
  int nacc = 0;

  // reference reservation
  bit          m_valid = 0;
  int          m_ctx = 0;
  logic [31:0] m_addr = '0;
  logic [31:0] m_val = '0;

  function automatic logic [31:0] seed_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] peek_b(input logic [31:0] a);
    return bmem.exists(a) ? bmem[a] : seed_word(a);
  endfunction

  function automatic logic [31:0] peek_s(input logic [31:0] a);
    return shadow.exists(a) ? shadow[a] : seed_word(a);
  endfunction

  task automatic poke(input logic [31:0] a, input logic [31:0] v);
    bmem[a] = v;
    shadow[a] = v;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // memory responder
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_fault = 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        nacc++;
        if (mem_we) begin
          if (mem_addr == flt_wr) mem_fault = 1'b1;
          else bmem[mem_addr] = mem_wdata;
        end else begin
          if (mem_addr == flt_rd) mem_fault = 1'b1;
          else mem_rdata = peek_b(mem_addr);
        end
        mem_ack = 1'b1;
        wcnt = 0;
      end else begin
        wcnt++;
      end
    end
  end

  // One request: the model predicts, the monitor runs, the results are compared.
  task automatic run(input bit op, input int ctx, input logic [31:0] base,
                     input logic [15:0] ofs, input logic [31:0] wd, input string req);
    longint     sofs;
    logic [31:0] ea;
    bit         bad;
    int         e_code = 0;
    bit         e_rdwe = 0;
    logic [31:0] e_rd = '0;
    int         e_acc = 0;
    int         t = 0;
    sofs = ofs;
    if (sofs >= 32768) sofs = sofs - 65536;
    ea  = 32'(longint'(base) + sofs);
    bad = (ea >= 32'h8000_0000) || (ea % 4 != 0);
    if (bad) begin
      e_code = 1;
    end else if (!op) begin
      e_acc = 1;
      if (ea == flt_rd) e_code = 2;
      else begin
        e_rdwe = 1; e_rd = peek_s(ea);
        m_valid = 1; m_ctx = ctx; m_addr = ea; m_val = e_rd;
      end
    end else if (m_valid && ctx == m_ctx && ea == m_addr) begin
      m_valid = 0;
      e_acc = 1;
      if (ea == flt_rd) e_code = 2;
      else if (peek_s(ea) == m_val) begin
        e_acc = 2;
        if (ea == flt_wr) e_code = 3;
        else begin shadow[ea] = wd; e_rdwe = 1; e_rd = 32'd1; end
      end else begin
        e_rdwe = 1; e_rd = 32'd0;
      end
    end else begin
      e_rdwe = 1; e_rd = 32'd0;
    end

    nacc = 0;
    req_valid = 1'b1; req_op = op; req_ctx = 4'(ctx);
    req_base = base; req_ofs = ofs; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && t < 60) begin
      if (rd_we || exc_valid) chk(0, req, "output before done", {31'd0, rd_we}, 32'd0);
      @(negedge clk);
      t++;
    end
    chk(done, req, "done", {31'd0, done}, 32'd1);
    chk(rd_we == e_rdwe, req, "rd_we", {31'd0, rd_we}, {31'd0, e_rdwe});
    if (e_rdwe) chk(rd_data == e_rd, req, "rd_data", rd_data, e_rd);
    chk(exc_valid == (e_code != 0), req, "exc_valid", {31'd0, exc_valid}, {31'd0, e_code != 0});
    chk(int'(exc_code) == e_code, req, "exc_code", {30'd0, exc_code}, 32'(e_code));
    if (e_code != 0) chk(exc_addr == ea, req, "exc_addr (R1)", exc_addr, ea);
    chk(nacc == e_acc, req, "memory accesses", 32'(nacc), 32'(e_acc));
    if (!bad) chk(peek_b(ea) == peek_s(ea), req, "memory word", peek_b(ea), peek_s(ea));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 / R8: idle state after reset
    chk(req_ready && !mem_req && !done, "R9", "reset idle", {29'd0, req_ready, mem_req, done}, 32'h4);
    chk(exc_code == 2'd0, "R9", "reset exc_code", {30'd0, exc_code}, 32'd0);

    // R9: conditional store straight after reset
    run(1, 1, 32'h0000_0100, 16'h0000, 32'h1111_1111, "R9");
    // R3 / R1: link with positive offset
    run(0, 1, 32'h0000_1000, 16'h0010, 32'h0, "R3");
    // R6 / R1: success with negative offset, back to back with the link
    run(1, 1, 32'h0000_1020, 16'hFFF0, 32'hCAFE_0001, "R6");
    // R5: reservation consumed
    run(1, 1, 32'h0000_1010, 16'h0000, 32'hDEAD_0002, "R5");

    // R6: value changed behind the monitor
    run(0, 2, 32'h0000_2000, 16'h0000, 32'h0, "R3");
    repeat (2) @(negedge clk);
    poke(32'h0000_2000, 32'h7777_7777);
    run(1, 2, 32'h0000_2000, 16'h0000, 32'hBBBB_BBBB, "R6");
    run(1, 2, 32'h0000_2000, 16'h0000, 32'hBBBB_BBBB, "R5");

    // R4: context and address mismatches leave the reservation alive
    run(0, 3, 32'h0000_3000, 16'h0000, 32'h0, "R3");
    run(1, 4, 32'h0000_3000, 16'h0000, 32'h4444_4444, "R4");
    run(1, 3, 32'h0000_3000, 16'h0004, 32'h4444_4444, "R4");
    run(1, 3, 32'h0000_3000, 16'h0000, 32'h3333_3333, "R4");

    // R2: misaligned and upper-half addresses
    run(0, 5, 32'h0000_1002, 16'h0000, 32'h0, "R2");
    run(1, 5, 32'h7FFF_FFF0, 16'h0020, 32'h0, "R2");
    run(0, 5, 32'h0000_4000, 16'h0000, 32'h0, "R3");
    run(1, 5, 32'h0000_4000, 16'h0001, 32'h5555_5555, "R2");
    run(1, 5, 32'h0000_4000, 16'h0000, 32'h5555_5555, "R2");

    // R7: read fault in link, write fault and read fault in conditional store
    flt_rd = 32'h0000_5000;
    run(0, 6, 32'h0000_5000, 16'h0000, 32'h0, "R7");
    flt_rd = 32'hFFFF_FFFF;
    run(0, 6, 32'h0000_6000, 16'h0000, 32'h0, "R3");
    flt_wr = 32'h0000_6000;
    run(1, 6, 32'h0000_6000, 16'h0000, 32'h6666_6666, "R7");
    flt_wr = 32'hFFFF_FFFF;
    run(0, 7, 32'h0000_7000, 16'h0000, 32'h0, "R3");
    flt_rd = 32'h0000_7000;
    run(1, 7, 32'h0000_7000, 16'h0000, 32'h7070_7070, "R7");
    flt_rd = 32'hFFFF_FFFF;
    run(1, 7, 32'h0000_7000, 16'h0000, 32'h7070_7070, "R5");

    // R8: slow memory
    lat = 3;
    run(0, 8, 32'h0000_8000, 16'h0008, 32'h0, "R8");
    run(1, 8, 32'h0000_8008, 16'h0000, 32'h8888_0008, "R8");
    lat = 1;
    for (int i = 0; i < 6; i++) begin
      run(0, i, 32'h0000_9000 + 32'(i * 16), 16'h0000, 32'h0, "R3");
      if (i % 2 == 0) repeat (i) @(negedge clk);
      run(1, (i == 3) ? 9 : i, 32'h0000_9000 + 32'(i * 16), 16'h0000, 32'hA000_0000 + 32'(i), "R6");
    end
    lat = 0;

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule